// File: doc/BRIEF.md
# Page Permission Checker

This block decides whether one memory access may proceed, given the leaf entry of a translation table that a walker has already fetched. It takes the entry, the kind of access (instruction fetch, data load or data store) and the context of the request: whether the processor runs in problem (user) state, whether the check belongs to the partition-scoped stage, whether the request came from a user-mode translation index, and a 3-bit authority-mask permission set. From these it derives the read/write/execute rights that the entry grants in this context, a fault flag, and a 3-bit cause vector.

The decision is pure logic, registered once at the output, so a result appears on the clock edge after the inputs are presented. The block holds no other state. A fetch from a page marked as non-idempotent I/O is refused before any rights are computed. Privileged pages are closed to problem-state code in the process-scoped stage. A supervisor touching an ordinary process-scoped page gets only the rights that both the entry and the authority mask allow.

Top module: `permchk_top`

## Requirements
- R1: When the access code is fetch (2'b00) and entry bits [5:4] equal the I/O attribute code (parameter `IO_ATTR`, default 2'b11), the result is a fault with cause 3'b001 (bit 0 = guarded fetch) and a granted set of 3'b000, whatever the other inputs are.
- R2: Otherwise, when the partition-scoped flag is low, the privileged bit (entry bit 3) is set and the problem-state flag is high, the granted set is 3'b000. This takes precedence over the user-mode index flag.
- R3: Otherwise, when the user-mode index flag is high, the privileged bit is set, or the partition-scoped flag is high, the granted set equals entry bits [2:0] (bit 2 = read, bit 1 = write, bit 0 = execute) and the authority mask has no effect.
- R4: In every remaining case, the granted set is entry bits [2:0] ANDed with the authority mask, using the same bit layout.
- R5: Outside R1, a fault is raised with cause bit 1 (protection) set exactly when the right the access needs is missing from the granted set: fetch (2'b00) needs execute, load (2'b01) needs read, store (2'b10) needs write.
- R6: Cause bit 2 (store) is set only with a protection fault on a store. Fetch and load faults leave it clear.
- R7: Access code 2'b11 needs no right and never faults. The granted set is still reported by R2 to R4.
- R8: Outputs change only on the rising clock edge following the inputs, and an active-low reset clears the granted set, the fault flag and the cause to zero at once.
- R9: Entry bits above bit 5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| entryIn | input | ENTRY_W | Leaf table entry under test |
| accType | input | 2 | Access code: 00 fetch, 01 load, 10 store, 11 none |
| probState | input | 1 | Request issued in problem (user) state |
| partScoped | input | 1 | Check belongs to the partition-scoped stage |
| userIdx | input | 1 | Request came from a user-mode translation index |
| authMask | input | 3 | Authority-mask rights: bit 2 read, bit 1 write, bit 0 execute |
| grantOut | output | 3 | Registered granted rights, same layout as authMask |
| faultOut | output | 1 | Registered fault flag |
| causeOut | output | 3 | Registered cause: bit 0 guarded fetch, bit 1 protection, bit 2 store |

## Verification
The properties assume that the inputs are free of X and settle before each rising edge. Every input combination, including access code 2'b11, counts as legal, so the properties set no other limit on the inputs. They relate each registered output to the inputs sampled one edge earlier. They only start once a full cycle has passed after reset, because the first edge after reset only loads the register. The bench changes inputs on falling edges and reads outputs on the next falling edge, so every sample falls half a period clear of the capturing edge. It fills the bits above the attribute field with all-ones or all-zeros patterns in turn, which never take the inputs outside what the properties allow.

// File: rtl/permchk_pkg.sv
package permchk_pkg;

  localparam int PERM_W  = 3;
  localparam int CAUSE_W = 3;
  localparam int FIELD_W = 6;

  localparam int PERM_X  = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_R  = 2;
  localparam int PRIV_BIT = 3;
  localparam int ATTR_LO = 4;
  localparam int ATTR_HI = 5;

  localparam int CAUSE_GUARD = 0;
  localparam int CAUSE_PROT  = 1;
  localparam int CAUSE_STORE = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_NONE  = 2'b11
  } acc_e;

  typedef struct packed {
    logic              guardHit;
    logic              denyAll;
    logic              useMask;
    logic              isStore;
    logic [PERM_W-1:0] needPerm;
  } ctlStrobes_t;

endpackage

// File: rtl/permchk_ctl.sv
module permchk_ctl
  import permchk_pkg::*;
#(
  parameter logic [1:0] IO_ATTR = 2'b11
) (
  input  logic [1:0]  attrField,
  input  logic        privBit,
  input  logic [1:0]  accType,
  input  logic        probState,
  input  logic        partScoped,
  input  logic        userIdx,
  output ctlStrobes_t strobes
);

  acc_e accKind;
  logic isFetch;

  assign accKind = acc_e'(accType);
  assign isFetch = (accKind == ACC_FETCH);

  always_comb begin
    strobes          = '0;
    strobes.guardHit = isFetch && (attrField == IO_ATTR);
    strobes.denyAll  = !partScoped && privBit && probState;
    strobes.useMask  = !(userIdx || privBit || partScoped);
    strobes.isStore  = (accKind == ACC_STORE);
    unique case (accKind)
      ACC_FETCH: strobes.needPerm[PERM_X]     = 1'b1;
      ACC_LOAD:  strobes.needPerm[PERM_R]     = 1'b1;
      ACC_STORE: strobes.needPerm[PERM_W_BIT] = 1'b1;
      ACC_NONE:  strobes.needPerm             = '0;
    endcase
  end

endmodule

// File: rtl/permchk_dp.sv
module permchk_dp
  import permchk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PERM_W-1:0]  permBits,
  input  logic [PERM_W-1:0]  authMask,
  input  ctlStrobes_t        strobes,
  output logic [PERM_W-1:0]  grantOut,
  output logic               faultOut,
  output logic [CAUSE_W-1:0] causeOut
);

  logic [PERM_W-1:0]  grantNext;
  logic [PERM_W-1:0]  missing;
  logic               protFault;
  logic [CAUSE_W-1:0] causeNext;

  always_comb begin
    if (strobes.guardHit || strobes.denyAll) begin
      grantNext = '0;
    end else if (strobes.useMask) begin
      grantNext = permBits & authMask;
    end else begin
      grantNext = permBits;
    end
  end

  for (genvar gi = 0; gi < PERM_W; gi++) begin : g_need
    assign missing[gi] = strobes.needPerm[gi] && !grantNext[gi];
  end

  assign protFault = !strobes.guardHit && (|missing);

  always_comb begin
    causeNext              = '0;
    causeNext[CAUSE_GUARD] = strobes.guardHit;
    causeNext[CAUSE_PROT]  = protFault;
    causeNext[CAUSE_STORE] = protFault && strobes.isStore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOut <= '0;
      faultOut <= 1'b0;
      causeOut <= '0;
    end else begin
      grantOut <= grantNext;
      faultOut <= strobes.guardHit || protFault;
      causeOut <= causeNext;
    end
  end

endmodule

// File: rtl/permchk_top.sv
module permchk_top
  import permchk_pkg::*;
#(
  parameter int         ENTRY_W = 64,
  parameter logic [1:0] IO_ATTR = 2'b11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] entryIn,
  input  logic [1:0]         accType,
  input  logic               probState,
  input  logic               partScoped,
  input  logic               userIdx,
  input  logic [2:0]         authMask,
  output logic [2:0]         grantOut,
  output logic               faultOut,
  output logic [2:0]         causeOut
);

  ctlStrobes_t strobes;

  permchk_ctl #(.IO_ATTR(IO_ATTR)) u_ctl (
    .attrField (entryIn[ATTR_HI:ATTR_LO]),
    .privBit   (entryIn[PRIV_BIT]),
    .accType   (accType),
    .probState (probState),
    .partScoped(partScoped),
    .userIdx   (userIdx),
    .strobes   (strobes)
  );

  permchk_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .permBits(entryIn[PERM_W-1:0]),
    .authMask(authMask),
    .strobes (strobes),
    .grantOut(grantOut),
    .faultOut(faultOut),
    .causeOut(causeOut)
  );

endmodule

// File: rtl/permchk_sva.sv
module permchk_sva #(
  parameter int         ENTRY_W = 64,
  parameter logic [1:0] IO_ATTR = 2'b11
) (
  input logic               clk,
  input logic               rstN,
  input logic [ENTRY_W-1:0] entryIn,
  input logic [1:0]         accType,
  input logic               probState,
  input logic               partScoped,
  input logic               userIdx,
  input logic [2:0]         authMask,
  input logic [2:0]         grantOut,
  input logic               faultOut,
  input logic [2:0]         causeOut
);

  logic seenEdge;
  logic guardNow;
  logic denyNow;
  logic fullNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assign guardNow = (accType == 2'b00) && (entryIn[5:4] == IO_ATTR);
  assign denyNow  = !guardNow && !partScoped && entryIn[3] && probState;
  assign fullNow  = !guardNow && !denyNow && (userIdx || entryIn[3] || partScoped);

  p_guard_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(guardNow) |-> faultOut && causeOut == 3'b001 && grantOut == 3'b000);

  p_deny_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(denyNow) |-> grantOut == 3'b000);

  p_full_rights_r3: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(fullNow) |-> grantOut == $past(entryIn[2:0]));

  p_masked_rights_r4: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(!guardNow && !denyNow && !fullNow)
      |-> grantOut == ($past(entryIn[2:0]) & $past(authMask)));

  p_fetch_needs_x_r5: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(accType) == 2'b00 && !causeOut[0] |-> faultOut == !grantOut[0]);

  p_load_needs_r_r5: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(accType) == 2'b01 |-> faultOut == !grantOut[2]);

  p_store_needs_w_r5: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(accType) == 2'b10 |-> faultOut == !grantOut[1]);

  p_store_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    causeOut[2] |-> faultOut && causeOut[1] && $past(accType) == 2'b10);

  p_none_no_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge && $past(accType) == 2'b11 |-> !faultOut && causeOut == 3'b000);

  p_fault_has_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultOut == (causeOut[1:0] != 2'b00));

endmodule

bind permchk_top permchk_sva #(.ENTRY_W(ENTRY_W), .IO_ATTR(IO_ATTR)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .entryIn   (entryIn),
  .accType   (accType),
  .probState (probState),
  .partScoped(partScoped),
  .userIdx   (userIdx),
  .authMask  (authMask),
  .grantOut  (grantOut),
  .faultOut  (faultOut),
  .causeOut  (causeOut)
);

// File: tb/permchk_top_tb.sv
`timescale 1ns/1ps
module permchk_top_tb;

  localparam int ENTRY_W = 64;
  localparam int NV = 18;

  // {entry[5:0], acc, prob, part, uidx, mask, expGrant, expFault, expCause}
  localparam logic [20:0] VEC [NV] = '{
    21'b110111_00_0_0_0_111_000_1_001,
    21'b110111_01_0_0_0_111_111_0_000,
    21'b001111_01_1_0_1_111_000_1_010,
    21'b001111_01_1_1_0_000_111_0_000,
    21'b000101_00_1_0_1_000_101_0_000,
    21'b001110_10_0_0_0_000_110_0_000,
    21'b000111_01_0_0_0_011_011_1_010,
    21'b000110_10_0_0_0_111_110_0_000,
    21'b000101_10_1_0_1_000_101_1_110,
    21'b000110_00_1_0_1_000_110_1_010,
    21'b000011_01_0_1_0_000_011_1_010,
    21'b000000_11_0_0_0_000_000_0_000,
    21'b110000_11_1_0_0_111_000_0_000,
    21'b100001_00_0_1_0_000_001_0_000,
    21'b000111_00_0_0_0_110_110_1_010,
    21'b001111_10_1_0_0_111_000_1_110,
    21'b111111_00_1_1_1_111_000_1_001,
    21'b000111_01_0_0_1_000_111_0_000
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic [ENTRY_W-1:0] entryIn;
  logic [1:0]         accType;
  logic               probState;
  logic               partScoped;
  logic               userIdx;
  logic [2:0]         authMask;
  logic [2:0]         grantOut;
  logic               faultOut;
  logic [2:0]         causeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string vecTag [NV];

  always #2.5 clk = ~clk;

  permchk_top #(.ENTRY_W(ENTRY_W)) u_dut (
    .clk(clk), .rstN(rstN), .entryIn(entryIn), .accType(accType),
    .probState(probState), .partScoped(partScoped), .userIdx(userIdx),
    .authMask(authMask), .grantOut(grantOut), .faultOut(faultOut),
    .causeOut(causeOut)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int idx, input bit upperOnes);
    logic [20:0] v;
    v = VEC[idx];
    entryIn    = {{(ENTRY_W-6){upperOnes}}, v[20:15]};
    accType    = v[14:13];
    probState  = v[12];
    partScoped = v[11];
    userIdx    = v[10];
    authMask   = v[9:7];
  endtask

  task automatic checkVec(input int idx, input string tag);
    logic [20:0] v;
    v = VEC[idx];
    chk(tag, "grant", {5'd0, grantOut}, {5'd0, v[6:4]});
    chk(tag, "fault", {7'd0, faultOut}, {7'd0, v[3]});
    chk(tag, "cause", {5'd0, causeOut}, {5'd0, v[2:0]});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    finishRun();
  end

  initial begin
    vecTag = '{"R1", "R1", "R2", "R3", "R3", "R3", "R4", "R4", "R6",
               "R5", "R5", "R7", "R7", "R1", "R4", "R2", "R1", "R3"};
    rstN = 1'b0;
    drive(0, 1'b1);
    repeat (3) @(negedge clk);
    // R8: reset state holds even with a faulting request on the inputs
    chk("R8", "reset grant", {5'd0, grantOut}, 8'd0);
    chk("R8", "reset fault", {7'd0, faultOut}, 8'd0);
    chk("R8", "reset cause", {5'd0, causeOut}, 8'd0);
    rstN = 1'b1;

    // table walk, upper bits alternate between all ones and all zeros
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(i, i[0]);
      @(negedge clk);
      checkVec(i, vecTag[i]);
    end

    // R8: output is registered, not visible before the next edge
    @(negedge clk);
    drive(11, 1'b0);
    @(negedge clk);
    drive(0, 1'b0);
    #1;
    chk("R8", "pre-edge fault", {7'd0, faultOut}, 8'd0);
    @(negedge clk);
    chk("R8", "post-edge fault", {7'd0, faultOut}, 8'd1);

    // R9: upper entry bits have no effect
    drive(6, 1'b1);
    @(negedge clk);
    checkVec(6, "R9");
    drive(6, 1'b0);
    entryIn[ENTRY_W-1:6] = {(ENTRY_W-6){1'b0}} | 58'h2AA_AAAA_AAAA_AAAA;
    @(negedge clk);
    checkVec(6, "R9");

    // R8: asynchronous reset clears a faulting result mid-cycle
    drive(15, 1'b0);
    @(negedge clk);
    chk("R6", "store fault before reset", {5'd0, causeOut}, 8'd6);
    #1 rstN = 1'b0;
    #0.5;
    chk("R8", "async reset fault", {7'd0, faultOut}, 8'd0);
    chk("R8", "async reset cause", {5'd0, causeOut}, 8'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule